// File: doc/BRIEF.md
# Clocked Flag-Producing Arithmetic and Logic Unit

This block is a narrow arithmetic and logic unit for a small processor datapath. Each cycle it takes two operands and a 4-bit operation code. On the next rising clock edge it registers a result together with carry, zero and sign flags. The flags stay in their registers until the next operation, so later conditional branches can test them. Compare is issued as a subtract and test as an AND, with the result thrown away. Increment and decrement are issued as add and subtract with the second operand tied to one.

The opcode map has sixteen entries:

| Code | Operation |
|------|-----------|
| 0000 | add |
| 0001 | subtract |
| 0010 | add with carry |
| 0011 | subtract with borrow |
| 0100 | AND |
| 0101 | OR |
| 0110 | NOT of B |
| 0111 | XOR |
| 1000 | shift left logical |
| 1001 | shift right logical |
| 1010 | shift left arithmetic |
| 1011 | shift right arithmetic |
| 1100 | rotate left |
| 1101 | rotate right |
| 1110 | rotate left through carry |
| 1111 | rotate right through carry |

The carry-using arithmetic and the rotates through carry take their extra bit from the registered carry flag, so a chain of operations can extend past one word.

A synchronous reset clears the result and every flag.

Top module: `flag_alu`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are `res_o`=0, `carry_o`=0, `zero_o`=0 and `sign_o`=0.
- R2: Outputs change only at a rising edge. They reflect the operands and opcode sampled at that edge, and hold between edges whatever the inputs do.
- R3: Code 0000 gives A+B modulo 2^W, with `carry_o` set to the carry out of the top bit. Code 0001 gives A-B modulo 2^W, with `carry_o` set when A<B (a borrow).
- R4: Code 0010 gives A+B+C and code 0011 gives A-B-C, where C is the registered `carry_o` before the edge. The carry rule is the one in R3.
- R5: Codes 0100, 0101 and 0111 give A AND B, A OR B and A XOR B, and clear `carry_o`.
- R6: Code 0110 gives the bitwise inverse of B, ignores A, and clears `carry_o`.
- R7: Codes 1000 and 1010 shift A left by one and fill bit 0 with zero. `carry_o` takes the old top bit of A.
- R8: Code 1001 shifts A right by one and fills the top bit with zero. Code 1011 shifts A right by one and keeps the top bit. For both, `carry_o` takes the old bit 0 of A.
- R9: Code 1100 rotates A left by one. Code 1101 rotates A right by one. `carry_o` takes the bit that wraps around.
- R10: Code 1110 rotates left through carry: the old carry enters bit 0 and the old top bit leaves into `carry_o`. Code 1111 rotates right through carry: the old carry enters the top bit and the old bit 0 leaves into `carry_o`.
- R11: For every opcode, `zero_o` is set exactly when the registered result is zero, and `sign_o` equals the result's top bit.
- R12: For codes 1000 to 1111, B has no effect on the result or the flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| opnd_a | input | DATA_W | First operand |
| opnd_b | input | DATA_W | Second operand |
| op_sel | input | 4 | Operation code |
| res_o | output | DATA_W | Registered result |
| carry_o | output | 1 | Registered carry / borrow flag |
| zero_o | output | 1 | Registered zero flag |
| sign_o | output | 1 | Registered sign flag |

## Verification
The bench builds the unit with its default width of eight bits, so a reference model can be written with plain integers and every carry and borrow boundary is easy to reach. At that width, directed operands of 0x00, 0x7F, 0x80 and 0xFF hit the wrap-around, borrow and sign transitions of each operation. A long pseudo-random stream of opcodes chains the registered carry through add-with-carry, subtract-with-borrow and the through-carry rotates, so a wrong carry-in shows up one operation later.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

    localparam int unsigned OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 4'h0,
        OP_SUB = 4'h1,
        OP_ADC = 4'h2,
        OP_SBC = 4'h3,
        OP_AND = 4'h4,
        OP_OR  = 4'h5,
        OP_NOT = 4'h6,
        OP_XOR = 4'h7,
        OP_SHL = 4'h8,
        OP_SHR = 4'h9,
        OP_SAL = 4'hA,
        OP_SAR = 4'hB,
        OP_ROL = 4'hC,
        OP_ROR = 4'hD,
        OP_RCL = 4'hE,
        OP_RCR = 4'hF
    } alu_op_e;

    typedef enum logic [1:0] {
        CLS_ARITH = 2'd0,
        CLS_LOGIC = 2'd1,
        CLS_SHIFT = 2'd2
    } alu_cls_e;

    // Classify an opcode into the unit that serves it
    function automatic alu_cls_e op_class(input alu_op_e op);
        alu_cls_e cls;
        if (op[3])
            cls = CLS_SHIFT;
        else if (op[2])
            cls = CLS_LOGIC;
        else
            cls = CLS_ARITH;
        return cls;
    endfunction

endpackage

// File: rtl/flag_alu_arith.sv
// Adder/subtractor with optional carry-in; cout is carry (add) or borrow (sub)
module flag_alu_arith #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    input  logic         use_cin,
    output logic [W-1:0] res,
    output logic         cout
);
    localparam int unsigned EXT_W = W + 1;

    logic [EXT_W-1:0] a_ext;
    logic [EXT_W-1:0] b_ext;
    logic [EXT_W-1:0] c_ext;
    logic [EXT_W-1:0] sum;

    always_comb begin
        a_ext = {1'b0, a};
        b_ext = {1'b0, b};
        c_ext = {{W{1'b0}}, (use_cin & cin)};
        if (sub)
            sum = a_ext - b_ext - c_ext;
        else
            sum = a_ext + b_ext + c_ext;
        res  = sum[W-1:0];
        cout = sum[W];
    end

endmodule

// File: rtl/flag_alu_logic.sv
// Bitwise unit: sel 00 AND, 01 OR, 10 NOT B, 11 XOR
module flag_alu_logic #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [1:0]   sel,
    output logic [W-1:0] res
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_comb begin
            case (sel)
                2'b00:   res[i] = a[i] & b[i];
                2'b01:   res[i] = a[i] | b[i];
                2'b10:   res[i] = ~b[i];
                default: res[i] = a[i] ^ b[i];
            endcase
        end
    end

endmodule

// File: rtl/flag_alu_shift.sv
// Single-bit shifter/rotator on operand A; cin is the registered carry
module flag_alu_shift #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a,
    input  logic         cin,
    input  logic [2:0]   sel,
    output logic [W-1:0] res,
    output logic         cout
);
    localparam int unsigned MSB = W - 1;

    logic top_bit;
    logic low_bit;

    always_comb begin
        top_bit = a[MSB];
        low_bit = a[0];
        case (sel)
            3'b000, 3'b010: begin   // logical / arithmetic left
                res  = {a[MSB-1:0], 1'b0};
                cout = top_bit;
            end
            3'b001: begin           // logical right
                res  = {1'b0, a[MSB:1]};
                cout = low_bit;
            end
            3'b011: begin           // arithmetic right
                res  = {top_bit, a[MSB:1]};
                cout = low_bit;
            end
            3'b100: begin           // rotate left
                res  = {a[MSB-1:0], top_bit};
                cout = top_bit;
            end
            3'b101: begin           // rotate right
                res  = {low_bit, a[MSB:1]};
                cout = low_bit;
            end
            3'b110: begin           // rotate left through carry
                res  = {a[MSB-1:0], cin};
                cout = top_bit;
            end
            default: begin          // rotate right through carry
                res  = {cin, a[MSB:1]};
                cout = low_bit;
            end
        endcase
    end

endmodule

// File: rtl/flag_alu.sv
module flag_alu #(
    parameter int unsigned DATA_W = 8
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic [DATA_W-1:0]                     opnd_a,
    input  logic [DATA_W-1:0]                     opnd_b,
    input  logic [flag_alu_pkg::OP_W-1:0]         op_sel,
    output logic [DATA_W-1:0]                     res_o,
    output logic                                  carry_o,
    output logic                                  zero_o,
    output logic                                  sign_o
);
    import flag_alu_pkg::*;

    localparam int unsigned MSB = DATA_W - 1;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              cf;
        logic              zf;
        logic              sf;
    } alu_state_t;

    alu_state_t state_d, state_q;

    alu_op_e           op;
    alu_cls_e          cls;
    logic              ar_sub;
    logic              ar_use_c;
    logic [DATA_W-1:0] ar_res;
    logic              ar_cf;
    logic [DATA_W-1:0] lg_res;
    logic [DATA_W-1:0] sh_res;
    logic              sh_cf;

    always_comb begin
        op       = alu_op_e'(op_sel);
        cls      = op_class(op);
        ar_sub   = (op == OP_SUB) || (op == OP_SBC);
        ar_use_c = (op == OP_ADC) || (op == OP_SBC);
    end

    flag_alu_arith #(.W(DATA_W)) i_arith (
        .a       (opnd_a),
        .b       (opnd_b),
        .cin     (state_q.cf),
        .sub     (ar_sub),
        .use_cin (ar_use_c),
        .res     (ar_res),
        .cout    (ar_cf)
    );

    flag_alu_logic #(.W(DATA_W)) i_logic (
        .a   (opnd_a),
        .b   (opnd_b),
        .sel (op_sel[1:0]),
        .res (lg_res)
    );

    flag_alu_shift #(.W(DATA_W)) i_shift (
        .a    (opnd_a),
        .cin  (state_q.cf),
        .sel  (op_sel[2:0]),
        .res  (sh_res),
        .cout (sh_cf)
    );

    // Next-state computation
    always_comb begin
        state_d = state_q;
        case (cls)
            CLS_SHIFT: begin
                state_d.res = sh_res;
                state_d.cf  = sh_cf;
            end
            CLS_LOGIC: begin
                state_d.res = lg_res;
                state_d.cf  = 1'b0;
            end
            default: begin
                state_d.res = ar_res;
                state_d.cf  = ar_cf;
            end
        endcase
        state_d.zf = ~|state_d.res;
        state_d.sf = state_d.res[MSB];
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    assign res_o   = state_q.res;
    assign carry_o = state_q.cf;
    assign zero_o  = state_q.zf;
    assign sign_o  = state_q.sf;

endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] opnd_a,
    input logic [DATA_W-1:0] opnd_b,
    input logic [3:0]        op_sel,
    input logic [DATA_W-1:0] res_o,
    input logic              carry_o,
    input logic              zero_o,
    input logic              sign_o
);
    localparam int unsigned MSB = DATA_W - 1;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (res_o == '0) && !carry_o && !zero_o && !sign_o); // R1

    AST_ADD_SUM: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 4'h0) |=>
            ({carry_o, res_o} == ({1'b0, $past(opnd_a)} + {1'b0, $past(opnd_b)}))); // R3

    AST_LOGIC_NO_CARRY: assert property (@(posedge clk) disable iff (rst)
        (op_sel[3:2] == 2'b01) |=> !carry_o); // R5

    AST_NOT_OF_B: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 4'h6) |=> (res_o == ~$past(opnd_b))); // R6

    AST_RCL_LOOP: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 4'hE) |=>
            (res_o == {$past(opnd_a[MSB-1:0]), $past(carry_o)}) &&
            (carry_o == $past(opnd_a[MSB]))); // R10

    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (zero_o == (res_o == '0))); // R11

    AST_SIGN_FLAG: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (sign_o == res_o[MSB])); // R11

endmodule

bind flag_alu flag_alu_chk #(.DATA_W(DATA_W)) i_flag_alu_chk (
    .clk     (clk),
    .rst     (rst),
    .opnd_a  (opnd_a),
    .opnd_b  (opnd_b),
    .op_sel  (op_sel),
    .res_o   (res_o),
    .carry_o (carry_o),
    .zero_o  (zero_o),
    .sign_o  (sign_o)
);

// File: tb/test_flag_alu.sv
module test_flag_alu;

    localparam int CLK_NS = 8;
    localparam int W      = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] opnd_a = '0;
    logic [W-1:0] opnd_b = '0;
    logic [3:0]   op_sel = '0;
    logic [W-1:0] res_o;
    logic         carry_o;
    logic         zero_o;
    logic         sign_o;

    int n_cmp  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // reference state
    int exp_res = 0;
    int exp_cf  = 0;
    int exp_zf  = 0;
    int exp_sf  = 0;

    always #(CLK_NS/2) clk = ~clk;

    flag_alu #(.DATA_W(W)) i_flag_alu (
        .clk     (clk),
        .rst     (rst),
        .opnd_a  (opnd_a),
        .opnd_b  (opnd_b),
        .op_sel  (op_sel),
        .res_o   (res_o),
        .carry_o (carry_o),
        .zero_o  (zero_o),
        .sign_o  (sign_o)
    );

    // Behavioural model on integers
    task automatic model(input int op, input int a, input int b, input int c_in,
                         output int r, output int c);
        int t;
        case (op)
            0:  begin t = a + b;         c = (t > 255) ? 1 : 0; r = t % 256; end
            1:  begin t = a - b;         c = (t < 0) ? 1 : 0;   r = (t + 256) % 256; end
            2:  begin t = a + b + c_in;  c = (t > 255) ? 1 : 0; r = t % 256; end
            3:  begin t = a - b - c_in;  c = (t < 0) ? 1 : 0;   r = (t + 256) % 256; end
            4:  begin r = a & b;  c = 0; end
            5:  begin r = a | b;  c = 0; end
            6:  begin r = 255 - b; c = 0; end
            7:  begin r = a ^ b;  c = 0; end
            8, 10: begin r = (a * 2) % 256; c = a / 128; end
            9:  begin r = a / 2; c = a % 2; end
            11: begin r = a / 2 + ((a >= 128) ? 128 : 0); c = a % 2; end
            12: begin r = (a * 2) % 256 + a / 128; c = a / 128; end
            13: begin r = a / 2 + (a % 2) * 128; c = a % 2; end
            14: begin r = (a * 2) % 256 + c_in; c = a / 128; end
            default: begin r = a / 2 + c_in * 128; c = a % 2; end
        endcase
    endtask

    task automatic compare(input string tag);
        n_cmp++;
        if (int'(res_o) != exp_res || int'(carry_o) != exp_cf ||
            int'(zero_o) != exp_zf || int'(sign_o) != exp_sf) begin
            n_fail++;
            $display("FAIL %s: got res=%02h c=%0d z=%0d s=%0d, expected res=%02h c=%0d z=%0d s=%0d",
                     tag, res_o, carry_o, zero_o, sign_o, exp_res, exp_cf, exp_zf, exp_sf);
        end
    endtask

    // One operation: drive at the falling edge, check hold before the edge, check after it
    task automatic step(input logic do_rst, input logic [3:0] op,
                        input logic [7:0] a, input logic [7:0] b, input string tag);
        int r;
        int c;
        @(negedge clk);
        rst    = do_rst;
        op_sel = op;
        opnd_a = a;
        opnd_b = b;
        #1;
        compare("R2 hold before edge");
        if (do_rst) begin
            r = 0; c = 0;
        end else begin
            model(int'(op), int'(a), int'(b), exp_cf, r, c);
        end
        exp_res = r;
        exp_cf  = c;
        exp_zf  = (!do_rst && r == 0) ? 1 : 0;
        exp_sf  = (!do_rst && r >= 128) ? 1 : 0;
        @(posedge clk);
        #2;
        compare(tag);
    endtask

    initial begin
        #(CLK_NS * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] lf;
        step(1'b1, 4'h0, 8'h00, 8'h00, "R1 reset");
        step(1'b1, 4'h0, 8'hFF, 8'hFF, "R1 reset with active inputs");
        // R3 add / subtract
        step(1'b0, 4'h0, 8'hFF, 8'h01, "R3 add wraps, carry");
        step(1'b0, 4'h0, 8'h7F, 8'h01, "R3 add into sign");
        step(1'b0, 4'h1, 8'h05, 8'h05, "R3 sub equal, zero");
        step(1'b0, 4'h1, 8'h00, 8'h01, "R3 sub borrow");
        // R4 carry chain
        step(1'b0, 4'h2, 8'h10, 8'h20, "R4 adc with carry in");
        step(1'b0, 4'h0, 8'h80, 8'h80, "R4 setup carry");
        step(1'b0, 4'h3, 8'h00, 8'h00, "R4 sbc borrow from carry");
        step(1'b0, 4'h3, 8'h10, 8'h01, "R4 sbc chained borrow");
        // R5 logic
        step(1'b0, 4'h0, 8'hFF, 8'hFF, "R5 setup carry");
        step(1'b0, 4'h4, 8'hF0, 8'h3C, "R5 and clears carry");
        step(1'b0, 4'h5, 8'h80, 8'h01, "R5 or");
        step(1'b0, 4'h7, 8'hAA, 8'hAA, "R5 xor zero");
        // R6 NOT ignores A
        step(1'b0, 4'h6, 8'h00, 8'h0F, "R6 not of b, a=00");
        step(1'b0, 4'h6, 8'hFF, 8'h0F, "R6 not of b, a=ff");
        // R7 left shifts
        step(1'b0, 4'h8, 8'h81, 8'h00, "R7 shl carry out");
        step(1'b0, 4'hA, 8'h40, 8'h00, "R7 sal into sign");
        // R8 right shifts
        step(1'b0, 4'h9, 8'h81, 8'h00, "R8 shr zero fill");
        step(1'b0, 4'hB, 8'h81, 8'h00, "R8 sar keeps sign");
        step(1'b0, 4'h9, 8'h01, 8'h00, "R8 shr to zero");
        // R9 rotates
        step(1'b0, 4'hC, 8'h81, 8'h00, "R9 rol");
        step(1'b0, 4'hD, 8'h01, 8'h00, "R9 ror");
        // R10 through carry
        step(1'b0, 4'hE, 8'h80, 8'h00, "R10 rcl with carry in set");
        step(1'b0, 4'hF, 8'h00, 8'h00, "R10 rcr carry enters top");
        step(1'b0, 4'hE, 8'h00, 8'h00, "R10 rcl zero loop");
        // R11 flags
        step(1'b0, 4'h1, 8'h00, 8'h80, "R11 sign from result");
        step(1'b0, 4'h4, 8'h0F, 8'hF0, "R11 zero flag");
        // R12 shifts ignore B
        step(1'b0, 4'hC, 8'h5A, 8'h00, "R12 rol b=00");
        step(1'b0, 4'hC, 8'h5A, 8'hFF, "R12 rol b=ff");
        step(1'b0, 4'hF, 8'h33, 8'hFF, "R12 rcr b=ff");
        // mixed stream, compared every clock
        lf = 32'h1ACE_B00C;
        for (int i = 0; i < 600; i++) begin
            lf = lf ^ (lf << 13);
            lf = lf ^ (lf >> 17);
            lf = lf ^ (lf << 5);
            step(1'b0, lf[3:0], lf[15:8], lf[27:20], "R3 R4 R11 mixed stream");
        end
        step(1'b1, 4'h2, 8'h12, 8'h34, "R1 reset mid-run");
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

endmodule